// File: doc/BRIEF.md
# Grouped Interrupt Controller with Vector Readout

This block gathers a wide set of interrupt request lines and presents them to a processor as one interrupt output and a readable vector byte. Sources are organised in groups of eight. Each group owns four byte registers: a pending byte, a mask byte, a detection-kind byte and a sense byte. Software reaches them over a simple byte-wide register bus with a write strobe and a combinational read path. Every source can be detected either as a level or as a single edge, with high/rising or low/falling sense, but never on both edges.

Each request line passes through a two-flop synchroniser before detection. A source is a candidate when its pending bit and its mask bit are both set. The interrupt output is the registered OR of all candidates. The vector byte reports the highest-numbered candidate plus a fixed offset. The bare offset means nothing is pending. Because the vector is derived from registered state, two reads in a row agree unless a new event lands between them.

Top module: `grp_irq_ctrl`

## Requirements
- R1: Source n maps to group n/8, bit n%8. The byte addresses are: pending bytes at 0..23, mask bytes at 24..47, detection-kind bytes at 48..71, sense bytes at 72..95 (group g at base+g), and the vector at 96.
- R2: All mask, detection-kind and sense bytes reset to 0 (every source masked, level, active-high). A write to one of these bytes replaces it, and a read returns the written value.
- R3: Writing the pending byte of a group clears exactly the edge-mode pending bits written as 1. Bits written as 0 keep their state.
- R4: With detection-kind bit 1 (edge), sense bit 0 sets the pending bit on a rising input and sense bit 1 sets it on a falling input. The other transition sets nothing. The bit stays set after the input returns, until it is cleared by a write.
- R5: With detection-kind bit 0 (level), the pending bit equals the active level: input high for sense 0, input low for sense 1. A clear write has no effect while the level is active.
- R6: irq_o is 1 exactly when some source has both its pending and mask bits set, delayed one clock. It rises one clock after the pending bit, which itself appears on the third clock edge after the input changes. A pending but masked source never raises irq_o.
- R7: The vector byte reads as 0x10 plus the number of the highest-numbered source that is both pending and unmasked, or 0x10 when there is none. Scanning groups from high to low, MSB first, gives this same winner. Source 0 therefore also reads 0x10.
- R8: Writes to the vector address or to unmapped addresses (97 and up) change no register. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | N_GRP*GRP_W | Raw interrupt request lines, source n at bit n |
| bus_we | input | 1 | Register write strobe, one byte per clock |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
The bench builds the block with its default parameters: 24 groups of 8 sources, offset 0x10 and a 7-bit address. These defaults reach the top source 191, whose vector is 0xCF, the last byte of every register block, and the vector address 96 at the end of the map. Directed scenarios cover level and edge detection under both senses, and selective clearing inside one group. They also cover masking, priority among sources in far-apart groups, the source-0 vector ambiguity, and the exact clock on which irq_o rises.

// File: rtl/gic_pkg.sv
package gic_pkg;
  typedef enum logic [2:0] {
    BLK_PEND,
    BLK_MASK,
    BLK_KIND,
    BLK_SENSE,
    BLK_VEC,
    BLK_NONE
  } gic_blk_e;
endpackage

// File: rtl/gic_sync.sv
module gic_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/gic_group.sv
module gic_group #(
  parameter int GRP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GRP_W-1:0] src,
  input  logic             we_pend,
  input  logic             we_mask,
  input  logic             we_kind,
  input  logic             we_sense,
  input  logic [GRP_W-1:0] wdata,
  output logic [GRP_W-1:0] pend_q,
  output logic [GRP_W-1:0] mask_q,
  output logic [GRP_W-1:0] kind_q,
  output logic [GRP_W-1:0] sense_q
);
  logic [GRP_W-1:0] prev_q;
  logic [GRP_W-1:0] hit_edge;

  always_comb begin
    for (int i = 0; i < GRP_W; i++) begin
      hit_edge[i] = sense_q[i] ? (prev_q[i] & ~src[i]) : (src[i] & ~prev_q[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      pend_q  <= '0;
      mask_q  <= '0;
      kind_q  <= '0;
      sense_q <= '0;
    end else begin
      prev_q <= src;
      for (int i = 0; i < GRP_W; i++) begin
        if (!kind_q[i]) begin
          pend_q[i] <= src[i] ^ sense_q[i];
        end else if (hit_edge[i]) begin
          pend_q[i] <= 1'b1;
        end else if (we_pend && wdata[i]) begin
          pend_q[i] <= 1'b0;
        end
      end
      if (we_mask)  mask_q  <= wdata;
      if (we_kind)  kind_q  <= wdata;
      if (we_sense) sense_q <= wdata;
    end
  end
endmodule

// File: rtl/gic_prio.sv
module gic_prio #(
  parameter int N     = 192,
  parameter int IDX_W = 8
) (
  input  logic [N-1:0]     cand,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl
  import gic_pkg::*;
#(
  parameter int N_GRP      = 24,
  parameter int GRP_W      = 8,
  parameter int VEC_OFFSET = 16,
  parameter int ADDR_W     = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_GRP*GRP_W-1:0] irq_src,
  input  logic                   bus_we,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [7:0]             bus_wdata,
  output logic [7:0]             bus_rdata,
  output logic                   irq_o
);
  localparam int N_SRC    = N_GRP * GRP_W;
  localparam int GIDX_W   = (N_GRP > 1) ? $clog2(N_GRP) : 1;
  localparam int SIDX_W   = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam int VEC_ADDR = 4 * N_GRP;

  logic [N_SRC-1:0] src_s;
  logic [N_SRC-1:0] pend_f, mask_f, kind_f, sense_f;
  logic [N_SRC-1:0] cand;
  logic             found;
  logic [SIDX_W-1:0] win;
  logic [7:0]       vec;

  gic_blk_e         blk;
  logic [GIDX_W-1:0] gsel;
  logic [31:0]      a32;

  gic_sync #(.W(N_SRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_src), .q(src_s)
  );

  always_comb begin
    a32  = 32'(bus_addr);
    blk  = BLK_NONE;
    gsel = '0;
    if (a32 < N_GRP) begin
      blk = BLK_PEND;  gsel = GIDX_W'(a32);
    end else if (a32 < 2 * N_GRP) begin
      blk = BLK_MASK;  gsel = GIDX_W'(a32 - N_GRP);
    end else if (a32 < 3 * N_GRP) begin
      blk = BLK_KIND;  gsel = GIDX_W'(a32 - 2 * N_GRP);
    end else if (a32 < VEC_ADDR) begin
      blk = BLK_SENSE; gsel = GIDX_W'(a32 - 3 * N_GRP);
    end else if (a32 == VEC_ADDR) begin
      blk = BLK_VEC;
    end
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    logic hit;
    assign hit = bus_we && (gsel == GIDX_W'(g));
    gic_group #(.GRP_W(GRP_W)) u_grp (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     (src_s[g*GRP_W +: GRP_W]),
      .we_pend (hit && blk == BLK_PEND),
      .we_mask (hit && blk == BLK_MASK),
      .we_kind (hit && blk == BLK_KIND),
      .we_sense(hit && blk == BLK_SENSE),
      .wdata   (bus_wdata[GRP_W-1:0]),
      .pend_q  (pend_f[g*GRP_W +: GRP_W]),
      .mask_q  (mask_f[g*GRP_W +: GRP_W]),
      .kind_q  (kind_f[g*GRP_W +: GRP_W]),
      .sense_q (sense_f[g*GRP_W +: GRP_W])
    );
  end

  assign cand = pend_f & mask_f;

  gic_prio #(.N(N_SRC), .IDX_W(SIDX_W)) u_prio (
    .cand(cand), .found(found), .idx(win)
  );

  assign vec = found ? (8'(win) + 8'(VEC_OFFSET)) : 8'(VEC_OFFSET);

  always_comb begin
    bus_rdata = '0;
    case (blk)
      BLK_PEND:  bus_rdata = 8'(pend_f[int'(gsel)*GRP_W +: GRP_W]);
      BLK_MASK:  bus_rdata = 8'(mask_f[int'(gsel)*GRP_W +: GRP_W]);
      BLK_KIND:  bus_rdata = 8'(kind_f[int'(gsel)*GRP_W +: GRP_W]);
      BLK_SENSE: bus_rdata = 8'(sense_f[int'(gsel)*GRP_W +: GRP_W]);
      BLK_VEC:   bus_rdata = vec;
      default:   bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |cand;
  end
endmodule

// File: rtl/gic_chk.sv
module gic_chk #(
  parameter int N_GRP      = 24,
  parameter int GRP_W      = 8,
  parameter int VEC_OFFSET = 16,
  parameter int ADDR_W     = 7
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_we,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic [N_GRP*GRP_W-1:0] pend_f,
  input logic [N_GRP*GRP_W-1:0] mask_f,
  input logic [N_GRP*GRP_W-1:0] kind_f,
  input logic [7:0]             vec,
  input logic                   irq_o
);
  localparam int N_SRC = N_GRP * GRP_W;
  logic wr_pend;
  assign wr_pend = bus_we && (32'(bus_addr) < N_GRP);

  // R6
  irq_follows_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == $past(|(pend_f & mask_f)));

  // R7
  vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (~|(pend_f & mask_f)) |-> (vec == 8'(VEC_OFFSET)));

  // R7
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(vec) >= VEC_OFFSET) && (32'(vec) <= VEC_OFFSET + N_SRC - 1));

  // R3
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(pend_f) & ~pend_f & $past(kind_f))) |-> $past(wr_pend));

  // R2
  mask_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_f != $past(mask_f)) |-> $past(bus_we));
endmodule

bind grp_irq_ctrl gic_chk #(
  .N_GRP(N_GRP), .GRP_W(GRP_W), .VEC_OFFSET(VEC_OFFSET), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .pend_f(pend_f), .mask_f(mask_f), .kind_f(kind_f), .vec(vec), .irq_o(irq_o)
);

// File: tb/grp_irq_ctrl_tb.sv
module grp_irq_ctrl_tb;
  localparam int NG = 24;
  localparam int GW = 8;
  localparam int NS = NG * GW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] irq_src = '0;
  logic          bus_we = 1'b0;
  logic [6:0]    bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic          irq_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  grp_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o)
  );

  task automatic check(input string req, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_addr = 7'(a); bus_wdata = 8'(d); bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    bus_addr = 7'(a);
    #1 d = int'(bus_rdata);
  endtask

  task automatic rd_chk(input string req, input int a, input int exp);
    int d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic settle();
    repeat (5) @(posedge clk);
  endtask

  task automatic t_reset();
    rd_chk("R2 mask g0", 24, 0);
    rd_chk("R2 mask g23", 47, 0);
    rd_chk("R2 kind g23", 71, 0);
    rd_chk("R2 sense g0", 72, 0);
    rd_chk("R7 idle vector", 96, 8'h10);
    check("R6 irq idle", int'(irq_o), 0);
  endtask

  task automatic t_regs();
    wr(29, 8'hA5); wr(55, 8'h3C); wr(95, 8'h81);
    rd_chk("R2 mask g5", 29, 8'hA5);
    rd_chk("R2 kind g7", 55, 8'h3C);
    rd_chk("R1 sense g23", 95, 8'h81);
    rd_chk("R1 mask g6 untouched", 30, 0);
    wr(29, 0); wr(55, 0); wr(95, 0);
    rd_chk("R2 kind cleared", 55, 0);
  endtask

  task automatic t_level();
    wr(25, 8'h20);
    @(negedge clk); irq_src[13] = 1'b1;
    settle();
    rd_chk("R5 level high pend", 1, 8'h20);
    rd_chk("R7 vector src13", 96, 13 + 16);
    check("R6 irq level", int'(irq_o), 1);
    wr(1, 8'h20);
    repeat (2) @(posedge clk);
    rd_chk("R5 clear ignored while active", 1, 8'h20);
    @(negedge clk); irq_src[13] = 1'b0;
    settle();
    rd_chk("R5 level drop", 1, 0);
    check("R6 irq drop", int'(irq_o), 0);
    wr(73, 8'h20);
    settle();
    rd_chk("R5 active-low pend", 1, 8'h20);
    @(negedge clk); irq_src[13] = 1'b1;
    settle();
    rd_chk("R5 active-low released", 1, 0);
    @(negedge clk); irq_src[13] = 1'b0;
    wr(73, 0); wr(25, 0);
    settle();
    rd_chk("R5 restored idle", 1, 0);
  endtask

  task automatic t_edge();
    int d;
    wr(60, 8'h30); wr(36, 8'h10);
    @(negedge clk); irq_src[100] = 1'b1;
    repeat (3) @(posedge clk);
    rd(96, d);
    check("R6 pend on 3rd edge (vector)", d, 100 + 16);
    check("R6 irq not yet", int'(irq_o), 0);
    @(posedge clk); #1;
    check("R6 irq one clock later", int'(irq_o), 1);
    @(negedge clk); irq_src[100] = 1'b0;
    settle();
    rd_chk("R4 rising latched", 12, 8'h10);
    wr(12, 8'h10);
    settle();
    rd_chk("R3 clear edge bit", 12, 0);
    check("R6 irq after clear", int'(irq_o), 0);
    wr(84, 8'h10);
    @(negedge clk); irq_src[100] = 1'b1;
    settle();
    rd_chk("R4 falling mode ignores rise", 12, 0);
    @(negedge clk); irq_src[100] = 1'b0;
    settle();
    rd_chk("R4 falling detected", 12, 8'h10);
    wr(84, 0);
    @(negedge clk); irq_src[101] = 1'b1;
    settle();
    rd_chk("R4 two edge bits", 12, 8'h30);
    wr(12, 8'h10);
    rd_chk("R3 selective clear", 12, 8'h20);
    wr(12, 8'h00);
    rd_chk("R3 zero write keeps", 12, 8'h20);
    wr(12, 8'h20);
    @(negedge clk); irq_src[101] = 1'b0;
    settle();
    rd_chk("R3 group cleared", 12, 0);
    wr(60, 0); wr(36, 0);
  endtask

  task automatic t_prio();
    @(negedge clk); irq_src[191] = 1'b1; irq_src[13] = 1'b1; irq_src[0] = 1'b1;
    settle();
    rd_chk("R1 src191 in g23 bit7", 23, 8'h80);
    check("R6 masked no irq", int'(irq_o), 0);
    rd_chk("R7 masked vector idle", 96, 8'h10);
    wr(47, 8'h80); wr(25, 8'h20); wr(24, 8'h01);
    settle();
    rd_chk("R7 highest wins 191", 96, 8'hCF);
    wr(47, 0);
    rd_chk("R7 next is 13", 96, 13 + 16);
    wr(25, 0);
    settle();
    rd_chk("R7 source0 reads offset", 96, 8'h10);
    check("R6 irq for source0", int'(irq_o), 1);
    wr(24, 0);
    @(negedge clk); irq_src = '0;
    settle();
    check("R6 irq off", int'(irq_o), 0);
  endtask

  task automatic t_readonly();
    wr(36, 8'h10); wr(60, 8'h10);
    @(negedge clk); irq_src[100] = 1'b1;
    settle();
    wr(96, 8'h55); wr(100, 8'hFF); wr(127, 8'hFF);
    rd_chk("R8 vector unchanged", 96, 100 + 16);
    rd_chk("R8 unmapped reads 0", 100, 0);
    rd_chk("R8 mask intact", 36, 8'h10);
    rd_chk("R8 pend intact", 12, 8'h10);
    @(negedge clk); irq_src[100] = 1'b0;
    wr(12, 8'h10); wr(36, 0); wr(60, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_level();
    t_edge();
    t_prio();
    t_readonly();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule